// File: doc/BRIEF.md
# Branch and Loop Condition Unit

This unit resolves the two control-transfer groups of a small 8-bit accumulator processor. For a conditional branch it decides from the opcode and the current minus, zero and carry flags whether the branch is taken. For a decrement-and-branch-if-not-zero loop it computes the decremented operand for write-back and branches on a non-zero result. In both cases it produces the next instruction pointer. Operand fetch, stack handling for calls and returns, and the write-back itself belong to neighbouring blocks.

The sequencer presents an opcode together with the address of its first byte, the flags, the loop operand and the target field, and raises `evalValid` for one cycle. One clock later the unit presents the decision, the new pointer and, for loops, the value to write back with its location code. The target field is either a signed 8-bit displacement, which is added to the address of the byte after the whole instruction, or a 16-bit absolute address. The relative form is two bytes long and the absolute form is three bytes long. Flags pass through untouched, because neither group changes them.

Top module: `branch_loop_unit`

## Requirements
- R1: While reset is asserted and after its release, `resValid`, `takeBranch` and `wbValid` are 0, and `nextPtr`, `wbData`, `wbLoc` and `flagsOut` are 0.
- R2: A branch has opcode bits 7:4 = 0010, bit 3 = invert, and bits 2:0 = a mask where bit 2 selects M, bit 1 selects Z and bit 0 selects C. It is taken exactly when invert XOR (OR of the selected flags) is 1.
- R3: Branch condition 1000 is taken for every flag value. Branch condition 0000 is never taken.
- R4: A taken relative-form instruction (`targetAbs`=0) gives `nextPtr` = opPtr + 2 + sign-extended `targetField[7:0]`, modulo 2^16.
- R5: A taken absolute-form instruction (`targetAbs`=1) gives `nextPtr` = `targetField`.
- R6: A not-taken instruction gives `nextPtr` = opPtr + 2 for the relative form and opPtr + 3 for the absolute form, modulo 2^16.
- R7: A loop has opcode bits 7:4 = 0011. It raises `wbValid` with `wbData` = operand − 1 modulo 256 and `wbLoc` = opcode bits 3:0 (the register/memory bit followed by the 3-bit select).
- R8: A loop is taken exactly when the decremented value is non-zero. Operand 0x00 gives 0xFF and is taken. Operand 0x01 gives 0x00 and is not taken.
- R9: For both groups, `flagsOut` = {M,Z,C} as presented with the opcode. A branch never raises `wbValid`.
- R10: An opcode outside both groups produces `resValid`=0, `takeBranch`=0 and `wbValid`=0 in the following cycle.
- R11: Results appear exactly one clock after `evalValid`. A cycle without `evalValid` is followed by `resValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | Request to evaluate the presented instruction |
| opcode | input | 8 | Instruction opcode |
| flagM | input | 1 | Minus flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| loopOperand | input | 8 | Current value of the loop counter operand |
| opPtr | input | 16 | Address of the opcode byte |
| targetAbs | input | 1 | 1: absolute 16-bit target, 0: 8-bit displacement |
| targetField | input | 16 | Absolute target, or displacement in bits 7:0 |
| resValid | output | 1 | Result valid |
| takeBranch | output | 1 | Branch taken |
| nextPtr | output | 16 | New instruction pointer |
| wbValid | output | 1 | Loop write-back request |
| wbData | output | 8 | Decremented operand |
| wbLoc | output | 4 | Write-back location code |
| flagsOut | output | 3 | Unchanged flags {M,Z,C} |

## Verification
The bench builds the unit with its default 16-bit pointer and 8-bit operand and displacement widths. At these sizes every one of the 16 branch condition codes can be crossed with all eight flag combinations and both target forms. Every one of the 256 loop operand values, including the 0x00 wrap, can be applied. Pointers near 0xFFFF and displacements of 0x7F and 0x80 are used to reach wrap-around of the pointer addition. All 224 opcodes outside both groups are also swept.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int OP_W = 8;
  localparam logic [3:0] GRP_BRANCH = 4'b0010;
  localparam logic [3:0] GRP_LOOP   = 4'b0011;

  typedef struct packed {
    logic load;    // capture a result this cycle
    logic isLoop;  // loop group: write back decremented value
    logic take;    // transfer control
  } blu_strobe_t;
endpackage

// File: rtl/blu_ctrl.sv
module blu_ctrl
  import blu_pkg::*;
(
  input  logic              evalValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic              flagM,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              decZero,
  output blu_strobe_t       strobes
);
  logic       brGrp;
  logic       loopGrp;
  logic       condInv;
  logic [2:0] condMask;
  logic [2:0] flagVec;
  logic [2:0] hitVec;
  logic       condHit;

  assign brGrp    = (opcode[7:4] == GRP_BRANCH);
  assign loopGrp  = (opcode[7:4] == GRP_LOOP);
  assign condInv  = opcode[3];
  assign condMask = opcode[2:0];
  assign flagVec  = {flagM, flagZ, flagC};

  for (genvar i = 0; i < 3; i++) begin : g_sel
    assign hitVec[i] = condMask[i] & flagVec[i];
  end

  assign condHit = |hitVec;

  always_comb begin
    strobes.load   = evalValid & (brGrp | loopGrp);
    strobes.isLoop = loopGrp;
    if (brGrp)
      strobes.take = condInv ^ condHit;
    else if (loopGrp)
      strobes.take = ~decZero;
    else
      strobes.take = 1'b0;
  end
endmodule

// File: rtl/blu_datapath.sv
module blu_datapath
  import blu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  blu_strobe_t       strobes,
  input  logic [3:0]        locCode,
  input  logic [2:0]        flagsIn,
  input  logic [DATA_W-1:0] loopOperand,
  input  logic [ADDR_W-1:0] opPtr,
  input  logic              targetAbs,
  input  logic [ADDR_W-1:0] targetField,
  output logic              decZero,
  output logic              resValid,
  output logic              takeBranch,
  output logic [ADDR_W-1:0] nextPtr,
  output logic              wbValid,
  output logic [DATA_W-1:0] wbData,
  output logic [3:0]        wbLoc,
  output logic [2:0]        flagsOut
);
  localparam logic [ADDR_W-1:0] LEN_REL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LEN_ABS = ADDR_W'(3);

  logic [DATA_W-1:0] decVal;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] fallPtr;
  logic [ADDR_W-1:0] relPtr;
  logic [ADDR_W-1:0] takenPtr;

  assign decVal  = loopOperand - DATA_W'(1);
  assign decZero = (decVal == '0);

  if (ADDR_W > DISP_W) begin : g_sext
    assign dispExt = {{(ADDR_W-DISP_W){targetField[DISP_W-1]}}, targetField[DISP_W-1:0]};
  end else begin : g_nosext
    assign dispExt = targetField[ADDR_W-1:0];
  end

  assign fallPtr  = opPtr + (targetAbs ? LEN_ABS : LEN_REL);
  assign relPtr   = fallPtr + dispExt;
  assign takenPtr = targetAbs ? targetField : relPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      takeBranch <= 1'b0;
      wbValid    <= 1'b0;
      nextPtr    <= '0;
      wbData     <= '0;
      wbLoc      <= '0;
      flagsOut   <= '0;
    end else begin
      resValid   <= strobes.load;
      takeBranch <= strobes.load & strobes.take;
      wbValid    <= strobes.load & strobes.isLoop;
      if (strobes.load) begin
        nextPtr  <= strobes.take ? takenPtr : fallPtr;
        flagsOut <= flagsIn;
      end
      if (strobes.load && strobes.isLoop) begin
        wbData <= decVal;
        wbLoc  <= locCode;
      end
    end
  end
endmodule

// File: rtl/branch_loop_unit.sv
module branch_loop_unit
  import blu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [7:0]        opcode,
  input  logic              flagM,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic [DATA_W-1:0] loopOperand,
  input  logic [ADDR_W-1:0] opPtr,
  input  logic              targetAbs,
  input  logic [ADDR_W-1:0] targetField,
  output logic              resValid,
  output logic              takeBranch,
  output logic [ADDR_W-1:0] nextPtr,
  output logic              wbValid,
  output logic [DATA_W-1:0] wbData,
  output logic [3:0]        wbLoc,
  output logic [2:0]        flagsOut
);
  blu_strobe_t strobes;
  logic        decZero;

  blu_ctrl ctrl_i (
    .evalValid (evalValid),
    .opcode    (opcode),
    .flagM     (flagM),
    .flagZ     (flagZ),
    .flagC     (flagC),
    .decZero   (decZero),
    .strobes   (strobes)
  );

  blu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .locCode     (opcode[3:0]),
    .flagsIn     ({flagM, flagZ, flagC}),
    .loopOperand (loopOperand),
    .opPtr       (opPtr),
    .targetAbs   (targetAbs),
    .targetField (targetField),
    .decZero     (decZero),
    .resValid    (resValid),
    .takeBranch  (takeBranch),
    .nextPtr     (nextPtr),
    .wbValid     (wbValid),
    .wbData      (wbData),
    .wbLoc       (wbLoc),
    .flagsOut    (flagsOut)
  );
endmodule

// File: rtl/blu_checker.sv
module blu_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              evalValid,
  input logic [7:0]        opcode,
  input logic              flagM,
  input logic              flagZ,
  input logic              flagC,
  input logic [DATA_W-1:0] loopOperand,
  input logic [ADDR_W-1:0] opPtr,
  input logic              targetAbs,
  input logic [ADDR_W-1:0] targetField,
  input logic              resValid,
  input logic              takeBranch,
  input logic [ADDR_W-1:0] nextPtr,
  input logic              wbValid,
  input logic [DATA_W-1:0] wbData,
  input logic [3:0]        wbLoc,
  input logic [2:0]        flagsOut
);
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(evalValid) |-> !resValid);

  assert_branch_cond_R2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(opcode[7:4]) == 4'b0010) |->
      takeBranch == ($past(opcode[3]) ^ (|($past(opcode[2:0]) & $past({flagM, flagZ, flagC})))));

  assert_uncond_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(evalValid && opcode == 8'h28) |-> takeBranch);

  assert_never_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(evalValid && opcode == 8'h20) |-> !takeBranch);

  assert_fall_ptr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !takeBranch) |->
      nextPtr == ADDR_W'($past(opPtr) + ($past(targetAbs) ? 3 : 2)));

  assert_abs_ptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (takeBranch && $past(targetAbs)) |-> nextPtr == $past(targetField));

  assert_dbnz_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(evalValid && opcode[7:4] == 4'b0011) |->
      (wbValid && wbData == DATA_W'($past(loopOperand) - 1) && wbLoc == $past(opcode[3:0])));

  assert_dbnz_take_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> takeBranch == (wbData != '0));

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> flagsOut == $past({flagM, flagZ, flagC}));

  assert_branch_nowb_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(opcode[7:4] == 4'b0010) |-> !wbValid);

  assert_other_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(opcode[7:5] != 3'b001) |-> (!resValid && !takeBranch && !wbValid));
endmodule

bind branch_loop_unit blu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/branch_loop_unit_tb_top.sv
`timescale 1ns/1ps
module branch_loop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        evalValid;
  logic [7:0]  opcode;
  logic        flagM, flagZ, flagC;
  logic [7:0]  loopOperand;
  logic [15:0] opPtr;
  logic        targetAbs;
  logic [15:0] targetField;
  logic        resValid, takeBranch, wbValid;
  logic [15:0] nextPtr;
  logic [7:0]  wbData;
  logic [3:0]  wbLoc;
  logic [2:0]  flagsOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  branch_loop_unit dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive at a falling edge, result sampled at the next falling edge
  task automatic apply(input logic [7:0] op, input logic [2:0] fl, input logic [7:0] opnd,
                       input logic [15:0] ptr, input logic abs, input logic [15:0] tgt);
    evalValid = 1'b1; opcode = op; {flagM, flagZ, flagC} = fl;
    loopOperand = opnd; opPtr = ptr; targetAbs = abs; targetField = tgt;
    @(negedge clk);
  endtask

  function automatic logic [15:0] ptr_of(input logic take, input logic abs,
                                         input logic [15:0] ptr, input logic [15:0] tgt);
    logic [15:0] fall;
    fall = ptr + (abs ? 16'd3 : 16'd2);
    if (!take) return fall;
    if (abs) return tgt;
    return fall + {{8{tgt[7]}}, tgt[7:0]};
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] ptrs [3];
    logic [7:0]  disps [4];
    ptrs[0] = 16'h0000; ptrs[1] = 16'h1234; ptrs[2] = 16'hFFFE;
    disps[0] = 8'h00; disps[1] = 8'h7F; disps[2] = 8'h80; disps[3] = 8'hFE;
    rstN = 1'b0; evalValid = 1'b0; opcode = 8'h00; {flagM, flagZ, flagC} = 3'b000;
    loopOperand = 8'h00; opPtr = 16'h0; targetAbs = 1'b0; targetField = 16'h0;
    repeat (3) @(negedge clk);
    chk(!resValid && !takeBranch && !wbValid, "R1 flags in reset", {resValid, takeBranch, wbValid}, 0);
    chk(nextPtr == 0 && wbData == 0 && wbLoc == 0 && flagsOut == 0, "R1 data in reset", nextPtr, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!resValid && nextPtr == 0, "R1 after release", {resValid, nextPtr}, 0);

    // R2 R3 R4 R5 R6 R9: branch condition sweep
    for (int cc = 0; cc < 16; cc++)
      for (int fl = 0; fl < 8; fl++)
        for (int abs = 0; abs < 2; abs++)
          for (int pi = 0; pi < 3; pi++)
            for (int di = 0; di < 4; di++) begin
              logic [15:0] tgt;
              logic expTake;
              logic [15:0] expPtr;
              tgt = abs ? (ptrs[pi] ^ 16'hA5C3) + 16'(di) : {8'h00, disps[di]};
              expTake = cc[3] ^ (|(cc[2:0] & fl[2:0]));
              expPtr = ptr_of(expTake, abs[0], ptrs[pi], tgt);
              apply({4'b0010, cc[3:0]}, fl[2:0], 8'h55, ptrs[pi], abs[0], tgt);
              chk(resValid == 1'b1, "R11 branch valid", resValid, 1);
              chk(takeBranch == expTake, cc == 8 ? "R3 always" : (cc == 0 ? "R3 never" : "R2 condition"),
                  takeBranch, expTake);
              chk(nextPtr == expPtr, expTake ? (abs ? "R5 absolute" : "R4 relative") : "R6 fallthrough",
                  nextPtr, expPtr);
              chk(flagsOut == fl[2:0] && !wbValid, "R9 branch flags", {wbValid, flagsOut}, fl);
            end

    // R7 R8: loop sweep over all operand values
    for (int v = 0; v < 256; v++) begin
      logic [7:0] expDec;
      logic [15:0] tgt;
      logic [15:0] expPtr;
      expDec = 8'(v - 1);
      tgt = (v % 2) ? 16'(v * 257) : 16'(8'(v));
      expPtr = ptr_of(expDec != 0, v[0], 16'(v * 131), tgt);
      apply({4'b0011, 4'(v)}, 3'(v), 8'(v), 16'(v * 131), v[0], tgt);
      chk(wbValid && wbData == expDec, "R7 decrement", wbData, expDec);
      chk(wbLoc == 4'(v), "R7 location", wbLoc, v % 16);
      chk(takeBranch == (expDec != 0), v == 0 ? "R8 wrap 00" : (v == 1 ? "R8 exit 01" : "R8 take"),
          takeBranch, expDec != 0);
      chk(nextPtr == expPtr, "R8 pointer", nextPtr, expPtr);
      chk(flagsOut == 3'(v), "R9 loop flags", flagsOut, v % 8);
    end

    // R10: every opcode outside both groups
    for (int op = 0; op < 256; op++) begin
      if (op[7:5] != 3'b001) begin
        apply(8'(op), 3'b111, 8'h01, 16'h4000, 1'b0, 16'h0010);
        chk(!resValid && !takeBranch && !wbValid, "R10 other opcode", {resValid, takeBranch, wbValid}, 0);
      end
    end

    // R11: idle cycle after a taken branch
    apply(8'h28, 3'b000, 8'h00, 16'h0100, 1'b0, 16'h0004);
    chk(resValid && takeBranch, "R11 before idle", {resValid, takeBranch}, 3);
    evalValid = 1'b0;
    @(negedge clk);
    chk(!resValid && !takeBranch && !wbValid, "R11 idle", {resValid, takeBranch, wbValid}, 0);

    finish_run();
  end
endmodule